// File: doc/BRIEF.md
# Stop-Mode Wake and Crystal Startup Controller

This block governs a clock-stopped low-power state for an 8-bit microcontroller core. It runs on the free-running oscillator clock and watches the special-function-register write bus. When software writes the power-control register with the stop bit set, it drops the core clock enable and holds the stop flag. While stopped, only a reset or an edge on one of the enabled external interrupt lines can end the state. Internal sources cannot end it, because they would need a running core clock.

A qualifying edge is captured in a wake latch, and a crystal-stabilization counter then starts. The clock enable stays low until the counter has covered its full count. At that point clocking resumes, the stop flag clears and the latch empties. A one-hot wake-source output names the line that ended the stop. It holds that value until the next stop entry. Reset returns the block to the running state at once, whatever phase it is in.

Top module: `stop_wake_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) forces clk_en=1, stop_flag=0 and wake_src=0 at once. This holds during a startup count, which is abandoned, so no later transition follows.
- R2: While stop_flag is 1, clk_en is 0.
- R3: A write with sfr_we=1, sfr_addr=8'h87 and sfr_wdata bit 1 set, made while running, sets stop_flag and drops clk_en at the same clock edge. A write to another address, or one with bit 1 clear, changes nothing.
- R4: While stopped, a falling edge on ext_int_n[i] starts the wake when int_wake_en[i]=1. Edges on lines whose enable is 0 are ignored. Edges that arrive while running are ignored.
- R5: clk_en returns to 1 on the (SYNC_STAGES+1+STARTUP_CYCLES)-th rising clock edge after the falling pin change. The change is made between edges. With the defaults this is 65,539 edges.
- R6: stop_flag clears on the same edge at which clk_en returns to 1.
- R7: wake_src is one-hot and bit i names the line that ended the stop. If several lines fall in the same cycle, the lowest index wins. wake_src holds until the next stop entry, which clears it to 0.
- R8: Edges on any line during the startup count neither restart the count nor alter wake_src.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, also a wake source |
| sfr_we | input | 1 | Special-function-register write strobe |
| sfr_addr | input | 8 | Register address of the write |
| sfr_wdata | input | 8 | Write data |
| ext_int_n | input | LINES | External interrupt pins, active low |
| int_wake_en | input | LINES | Per-line permission to wake from stop |
| clk_en | output | 1 | Core clock enable |
| stop_flag | output | 1 | Stop bit as read back by the core |
| wake_src | output | LINES | One-hot line that ended the last stop |

## Verification
The bench builds the main instance with STARTUP_CYCLES=24, SYNC_STAGES=2 and four lines. This makes many stop and wake rounds affordable, so the bench can cover:
- disabled lines and edges while running;
- simultaneous edges;
- edges during startup;
- a reset that lands mid-count.

A second instance keeps the default 65,536-cycle count and checks the exact full wake latency once.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;

  typedef enum logic [1:0] {
    SW_RUN     = 2'd0,
    SW_STOPPED = 2'd1,
    SW_STARTUP = 2'd2
  } sw_state_e;

  // isolate the lowest set bit of a vector
  function automatic logic [31:0] lowest_onehot(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

  // true when a bus write sets the stop bit of the power-control register
  function automatic logic is_stop_write(input logic       we,
                                         input logic [7:0] addr,
                                         input logic [7:0] data,
                                         input logic [7:0] ctl_addr,
                                         input logic [2:0] bit_idx);
    return we && (addr == ctl_addr) && data[bit_idx];
  endfunction

endpackage

// File: rtl/sw_edge_detect.sv
module sw_edge_detect #(
  parameter int SYNC_STAGES = 2,
  parameter bit FALLING     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic edge_hit
);
  localparam logic IDLE = FALLING;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{IDLE}};
      prev_q <= IDLE;
    end else begin
      sync_q <= (sync_q << 1) | SYNC_STAGES'(pin);
      prev_q <= cur;
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_hit = prev_q & ~cur;
    end else begin : g_rise
      assign edge_hit = ~prev_q & cur;
    end
  endgenerate

  // R4: one pin transition yields a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> !edge_hit);

endmodule

// File: rtl/sw_startup_timer.sv
module sw_startup_timer #(
  parameter int COUNT = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int              CW   = $clog2(COUNT + 1);
  localparam logic [CW-1:0]   LAST = CW'(COUNT - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || done)    cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  // R5: the count advances by one every running cycle until the end
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done) |=> (cnt == CW'($past(cnt) + 1'b1)));

  // R5: finishing restarts from zero
  a_r5_done_restart: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt == '0));

endmodule

// File: rtl/sw_stop_fsm.sv
module sw_stop_fsm
  import stop_wake_pkg::*;
#(
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic [LINES-1:0] edge_vec,
  input  logic [LINES-1:0] wake_en,
  input  logic             timer_done,
  output logic             timer_run,
  output logic             clk_en,
  output logic             stop_flag,
  output logic [LINES-1:0] wake_src
);
  sw_state_e        state;
  logic             wake_pend;
  logic [LINES-1:0] wake_hits;
  logic             wake_hit;

  assign wake_hits = edge_vec & wake_en;
  assign wake_hit  = |wake_hits;
  assign timer_run = (state == SW_STARTUP);
  assign clk_en    = (state == SW_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SW_RUN;
      stop_flag <= 1'b0;
      wake_src  <= '0;
      wake_pend <= 1'b0;
    end else begin
      case (state)
        SW_RUN: begin
          if (stop_req) begin
            state     <= SW_STOPPED;
            stop_flag <= 1'b1;
            wake_src  <= '0;
          end
        end
        SW_STOPPED: begin
          if (wake_hit) begin
            state     <= SW_STARTUP;
            wake_pend <= 1'b1;
            wake_src  <= LINES'(lowest_onehot(32'(wake_hits)));
          end
        end
        SW_STARTUP: begin
          if (timer_done) begin
            state     <= SW_RUN;
            stop_flag <= 1'b0;
            wake_pend <= 1'b0;
          end
        end
        default: state <= SW_RUN;
      endcase
    end
  end

  // R2: clocks stay gated for as long as the stop flag is up
  a_r2_gated_while_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag |-> !clk_en);

  // R3: a stop write while running gates the clock at the next edge
  a_r3_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && stop_req) |=> (stop_flag && !clk_en && wake_src == '0));

  // R4: without an enabled edge the stopped state persists
  a_r4_stay_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SW_STOPPED && !wake_hit) |=> (state == SW_STOPPED));

  // R6: resumed clocking comes with a cleared stop flag
  a_r6_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> !stop_flag);

  // R7: wake source never names more than one line
  a_r7_src_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_src));

  // R8: source is frozen through the startup count
  a_r8_src_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SW_STARTUP) |=> $stable(wake_src));

  // R5: the wake latch is empty whenever clocks run
  a_r5_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> !wake_pend);

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import stop_wake_pkg::*;
#(
  parameter int         LINES          = 4,
  parameter int         STARTUP_CYCLES = 65536,
  parameter int         SYNC_STAGES    = 2,
  parameter bit         FALLING_EDGE   = 1'b1,
  parameter logic [7:0] PCON_ADDR      = 8'h87,
  parameter int         STOP_BIT       = 1
) (
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             sfr_we,
  input  logic [7:0]       sfr_addr,
  input  logic [7:0]       sfr_wdata,
  input  logic [LINES-1:0] ext_int_n,
  input  logic [LINES-1:0] int_wake_en,
  output logic             clk_en,
  output logic             stop_flag,
  output logic [LINES-1:0] wake_src
);
  localparam logic [2:0] STOP_IDX = 3'(STOP_BIT);

  logic             stop_req;
  logic [LINES-1:0] edge_vec;
  logic             timer_run;
  logic             timer_done;

  assign stop_req = is_stop_write(sfr_we, sfr_addr, sfr_wdata, PCON_ADDR, STOP_IDX);

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      sw_edge_detect #(
        .SYNC_STAGES (SYNC_STAGES),
        .FALLING     (FALLING_EDGE)
      ) u_edge (
        .clk      (osc_clk),
        .rst_n    (rst_n),
        .pin      (ext_int_n[i]),
        .edge_hit (edge_vec[i])
      );
    end
  endgenerate

  sw_startup_timer #(
    .COUNT (STARTUP_CYCLES)
  ) u_timer (
    .clk   (osc_clk),
    .rst_n (rst_n),
    .run   (timer_run),
    .done  (timer_done)
  );

  sw_stop_fsm #(
    .LINES (LINES)
  ) u_fsm (
    .clk        (osc_clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .edge_vec   (edge_vec),
    .wake_en    (int_wake_en),
    .timer_done (timer_done),
    .timer_run  (timer_run),
    .clk_en     (clk_en),
    .stop_flag  (stop_flag),
    .wake_src   (wake_src)
  );

  // R3: writes to other registers leave a running core running
  a_r3_other_addr: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (clk_en && sfr_we && sfr_addr != PCON_ADDR) |=> (clk_en && !stop_flag));

  // R5: clocks resume only on the edge the count ends
  a_r5_resume_on_done: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (timer_run && !timer_done) |=> !clk_en);

endmodule

// File: tb/tb_stop_wake_ctrl.sv
module tb_stop_wake_ctrl;
  localparam int N   = 4;
  localparam int SC  = 24;
  localparam int SS  = 2;
  localparam int LAT = SS + 1 + SC;
  localparam int LATL = 2 + 1 + 65536;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         sfr_we = 1'b0;
  logic [7:0]   sfr_addr = '0;
  logic [7:0]   sfr_wdata = '0;
  logic [N-1:0] ext_int_n = '1;
  logic [N-1:0] wake_en = '1;
  logic         clk_en, stop_flag;
  logic [N-1:0] wake_src;

  logic         l_we = 1'b0;
  logic [7:0]   l_addr = '0;
  logic [7:0]   l_wdata = '0;
  logic [N-1:0] l_int_n = '1;
  logic         l_clk_en, l_stop;
  logic [N-1:0] l_src;

  stop_wake_ctrl #(.LINES(N), .STARTUP_CYCLES(SC), .SYNC_STAGES(SS)) dut (
    .osc_clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .ext_int_n(ext_int_n), .int_wake_en(wake_en),
    .clk_en(clk_en), .stop_flag(stop_flag), .wake_src(wake_src));

  stop_wake_ctrl #(.LINES(N)) dut_long (
    .osc_clk(clk), .rst_n(rst_n), .sfr_we(l_we), .sfr_addr(l_addr),
    .sfr_wdata(l_wdata), .ext_int_n(l_int_n), .int_wake_en(4'b1111),
    .clk_en(l_clk_en), .stop_flag(l_stop), .wake_src(l_src));

  int cyc = 0;
  always @(posedge clk) cyc++;

  typedef struct {
    string        tag;
    int           at;
    logic         en;
    logic         stp;
    logic [N-1:0] src;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   checks = 0;
  int   errors = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  logic last_en = 1'b1;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic push_exp(input string tag, input int at, input logic en,
                          input logic stp, input logic [N-1:0] src);
    exp_t x;
    x.tag = tag; x.at = at; x.en = en; x.stp = stp; x.src = src;
    q.push_back(x);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  // monitor: every clk_en transition must match the next expected item
  always @(negedge clk) begin
    if (mon_on && clk_en !== last_en) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL unexpected transition R1/R4 got clk_en=%0b at cyc %0d exp none",
                 clk_en, cyc);
      end else begin
        e = q.pop_front();
        if (cyc != e.at || clk_en !== e.en || stop_flag !== e.stp || wake_src !== e.src) begin
          errors++;
          $display("FAIL %s got cyc=%0d en=%0b stop=%0b src=%0h exp cyc=%0d en=%0b stop=%0b src=%0h",
                   e.tag, cyc, clk_en, stop_flag, wake_src, e.at, e.en, e.stp, e.src);
        end
      end
      last_en = clk_en;
    end
  end

  initial begin
    int c1;
    step(3);
    rst_n = 1'b1;
    step(1);
    last_en = clk_en;
    mon_on = 1'b1;

    // R1 reset state
    chk("R1 clk_en after reset", clk_en, 1);
    chk("R1 stop_flag after reset", stop_flag, 0);
    chk("R1 wake_src after reset", wake_src, 0);

    // R3 writes that must not stop
    sfr_write(8'h86, 8'h02); step(3);
    chk("R3 other address ignored", stop_flag, 0);
    sfr_write(8'h87, 8'hFD); step(3);
    chk("R3 bit1 clear ignored", stop_flag, 0);

    // R4 edge while running
    ext_int_n[0] = 1'b0; step(4); ext_int_n[0] = 1'b1; step(4);
    chk("R4 edge while running ignored", clk_en, 1);

    // enter stop with line 1 disabled
    wake_en = 4'b1101;
    push_exp("R3 stop entry", cyc + 1, 1'b0, 1'b1, 4'b0000);
    sfr_write(8'h87, 8'h02); step(2);
    chk("R2 clock gated in stop", clk_en, 0);

    ext_int_n[1] = 1'b0; step(8); ext_int_n[1] = 1'b1; step(LAT + 4);
    chk("R4 disabled line ignored", clk_en, 0);
    chk("R2 stop flag kept", stop_flag, 1);

    // wake by line 2, line 0 toggles during startup
    push_exp("R5 R6 R7 wake line2", cyc + LAT, 1'b1, 1'b0, 4'b0100);
    ext_int_n[2] = 1'b0; step(6);
    ext_int_n[0] = 1'b0; step(4);
    ext_int_n = '1; step(LAT);
    chk("R8 src unchanged by startup edge", wake_src, 4'b0100);
    chk("R5 running after wake", clk_en, 1);

    // second stop clears src; simultaneous edges on lines 1 and 3
    wake_en = 4'b1111;
    push_exp("R7 src cleared at stop", cyc + 1, 1'b0, 1'b1, 4'b0000);
    sfr_write(8'h87, 8'h02); step(3);
    push_exp("R7 lowest index wins", cyc + LAT, 1'b1, 1'b0, 4'b0010);
    ext_int_n = 4'b0101; step(4); ext_int_n = '1; step(LAT + 2);
    chk("R7 src after simultaneous", wake_src, 4'b0010);

    // reset during startup aborts the count
    push_exp("R3 stop entry again", cyc + 1, 1'b0, 1'b1, 4'b0000);
    sfr_write(8'h87, 8'h02); step(3);
    ext_int_n[3] = 1'b0; step(SS + 6);
    ext_int_n[3] = 1'b1;
    push_exp("R1 reset aborts startup", cyc + 1, 1'b1, 1'b0, 4'b0000);
    #2 rst_n = 1'b0;
    step(1);
    rst_n = 1'b1;
    step(SC + 10);
    chk("R1 still running after abort", clk_en, 1);
    chk("R1 src cleared by reset", wake_src, 0);

    // full default count on the second instance
    l_we = 1'b1; l_addr = 8'h87; l_wdata = 8'h02;
    step(1); l_we = 1'b0; step(1);
    chk("R3 default instance stops", l_clk_en, 0);
    c1 = cyc;
    l_int_n[0] = 1'b0;
    do step(1); while (!l_clk_en && (cyc - c1) < LATL + 10);
    chk("R5 default wake latency", cyc - c1, LATL);
    chk("R7 default instance src", l_src, 4'b0001);
    chk("R6 default instance flag", l_stop, 0);

    step(2);
    chk("scoreboard drained R5", q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R5 got hung exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule